// File: doc/BRIEF.md
# Serial Peripheral Target with Host Status Handshake

This block is the target (slave) side of an 8-bit synchronous serial link, with a small register port facing a host processor. The external controller supplies the serial clock and an active-low select line. The block receives a byte on the data-in line and returns a byte on the data-out line, most significant bit first. Any of the four clock polarity and phase combinations can be chosen. The serial pins are brought into the system clock domain through synchronisers, so the serial clock must be slow compared with the system clock.

The host loads the next outgoing byte through the data register and reads the last received byte from the same address. A status register reports byte completion, receive overrun and write collision. The completion flag is cleared by a two-step handshake: a status read while a flag is up, followed by a data read. Data writes are refused while completion is pending and the status has not yet been read. An interrupt line reflects pending completion, gated by the enable bits in the control register.

Top module: `spi_tgt_port`

## Requirements
- R1: After reset the status, control and receive-buffer registers all read 0x00, the interrupt output is low, and the outgoing shift register holds 0x00, so the data-out line is low.
- R2: In each mode, the byte held in the shift register appears on the data-out line MSB first. Control bit 3 sets the idle clock level. Control bit 2 selects phase: 0 samples on the leading edge and shifts on the trailing edge; 1 shifts on the leading edge and samples on the trailing edge.
- R3: On the sampling edge of the eighth bit, the assembled byte is copied to the receive buffer and status bit 7 (completion) is set. A read of address 2 returns that byte.
- R4: A data read without a preceding status read leaves the flags unchanged. A status read (address 1) made while any flag is set, followed by a data read, clears status bits 7, 6 and 5.
- R5: A write to address 2 while bit 7 is set and no status read has happened since is ignored and sets no flag. After the status read, the write is accepted.
- R6: If a byte completes while bit 7 is still set, status bit 5 (overrun) is set and the receive buffer keeps the earlier byte.
- R7: With phase bit 0, a write to address 2 while select is low sets status bit 6 (collision) and does not change the outgoing byte.
- R8: With phase bit 1, a write to address 2 while select is low but between bytes is accepted. A write after the first clock edge of a byte and before its completion sets bit 6 and is dropped.
- R9: Raising select before the eighth sampling edge abandons the byte with no completion. The next byte after select falls again is received whole.
- R10: The interrupt output is high exactly when bit 7 is set and control bits 0 (enable) and 1 (interrupt enable) are both set.
- R11: While control bit 0 is clear, clock edges on the serial side complete no byte and set no flag.
- R12: Address 0 reads back control bits 3:0, with the upper bits reading 0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 control, 1 status, 2 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_sel is high |
| sck_in | input | 1 | Serial clock from the controller |
| csn_in | input | 1 | Active-low select from the controller |
| mosi_in | input | 1 | Serial data in |
| miso_out | output | 1 | Serial data out, driven low while deselected |
| irq_out | output | 1 | Completion interrupt |

## Verification
A wrong bit counter shows on the very next byte: the completion flag rises early or late, and the receive buffer holds a byte that is rotated against what the controller sent. A shift register that loses or duplicates a bit shows on data-out within one half serial period, before the next sampling edge. Flag state that is latched wrongly is visible at the following status read, or at the interrupt pin in the same system cycle. The sweep covers every mode with many byte values and compares each bit as it appears.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // control register layout, bit 3 down to bit 0
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic irq_en;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
      stg_q[0] <= d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_edges.sv
module spi_tgt_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  output logic lead_ev,
  output logic samp_ev,
  output logic shift_ev
);
  logic sck_q;
  logic moved;
  logic trail_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  always_comb begin
    moved    = sck_q ^ sck_s;
    lead_ev  = moved & (sck_s ^ cpol);
    trail_ev = moved & ~(sck_s ^ cpol);
    samp_ev  = cpha ? trail_ev : lead_ev;
    shift_ev = cpha ? lead_ev : trail_ev;
  end
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              lead_ev,
  input  logic              samp_ev,
  input  logic              shift_ev,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] shreg_q,
  output logic              busy_q,
  output logic [$clog2(DATA_W)-1:0] bitcnt_q,
  output logic              done_ev,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              smp_q, smp_d;
  logic              busy_d;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = bitcnt_q;
    smp_d   = smp_q;
    busy_d  = busy_q;
    done_ev = 1'b0;
    rx_byte = {shreg_q[DATA_W-2:0], mosi_s};
    if (!enable || !cs_act) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else begin
      if (lead_ev) busy_d = 1'b1;
      if (samp_ev) begin
        smp_d = mosi_s;
        if (bitcnt_q == LAST) begin
          done_ev = 1'b1;
          shreg_d = rx_byte;
          cnt_d   = '0;
          busy_d  = 1'b0;
        end else begin
          cnt_d = bitcnt_q + 1'b1;
        end
      end
      if (shift_ev && bitcnt_q != '0) shreg_d = {shreg_q[DATA_W-2:0], smp_q};
    end
    if (load_en) shreg_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      bitcnt_q <= '0;
      smp_q    <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      shreg_q  <= shreg_d;
      bitcnt_q <= cnt_d;
      smp_q    <= smp_d;
      busy_q   <= busy_d;
    end
  end
endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              done_ev,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              cs_act,
  input  logic              busy,
  output ctrl_t             ctrl_q,
  output logic              load_en,
  output logic              irq,
  output logic              done_q,
  output logic              ovr_q,
  output logic              col_q,
  output logic              armed_q,
  output logic              blocked,
  output logic [DATA_W-1:0] rxbuf_q
);
  localparam int unsigned BIT_DONE = DATA_W - 1;
  localparam int unsigned BIT_COL  = DATA_W - 2;
  localparam int unsigned BIT_OVR  = DATA_W - 3;

  ctrl_t             ctrl_d;
  logic              done_d, ovr_d, col_d, armed_d;
  logic [DATA_W-1:0] rxbuf_d;
  logic              rd_stat, rd_data, wr_data, wr_ctrl;
  logic              collide, clear, any_flag;

  always_comb begin
    rd_stat  = host_sel & ~host_wr & (host_addr == ADDR_STAT);
    rd_data  = host_sel & ~host_wr & (host_addr == ADDR_DATA);
    wr_data  = host_sel &  host_wr & (host_addr == ADDR_DATA);
    wr_ctrl  = host_sel &  host_wr & (host_addr == ADDR_CTRL);
    any_flag = done_q | ovr_q | col_q;
    blocked  = done_q & ~armed_q;
    collide  = ctrl_q.cpha ? busy : cs_act;
    load_en  = wr_data & ~blocked & ~collide;
    clear    = rd_data & armed_q;

    ctrl_d  = ctrl_q;
    done_d  = done_q;
    ovr_d   = ovr_q;
    col_d   = col_q;
    armed_d = armed_q;
    rxbuf_d = rxbuf_q;

    if (wr_ctrl) ctrl_d = ctrl_t'(host_wdata[3:0]);
    if (rd_stat && any_flag) armed_d = 1'b1;
    if (clear) begin
      done_d  = 1'b0;
      ovr_d   = 1'b0;
      col_d   = 1'b0;
      armed_d = 1'b0;
    end
    if (wr_data && !blocked && collide) col_d = 1'b1;
    if (done_ev) begin
      if (done_q && !clear) begin
        ovr_d = 1'b1;
      end else begin
        done_d  = 1'b1;
        rxbuf_d = rx_byte;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_CTRL: host_rdata[3:0] = ctrl_q;
      ADDR_STAT: begin
        host_rdata[BIT_DONE] = done_q;
        host_rdata[BIT_COL]  = col_q;
        host_rdata[BIT_OVR]  = ovr_q;
      end
      ADDR_DATA: host_rdata = rxbuf_q;
      default:   host_rdata = '0;
    endcase
    irq = done_q & ctrl_q.enable & ctrl_q.irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      col_q   <= 1'b0;
      armed_q <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      done_q  <= done_d;
      ovr_q   <= ovr_d;
      col_q   <= col_d;
      armed_q <= armed_d;
      rxbuf_q <= rxbuf_d;
    end
  end
endmodule

// File: rtl/spi_tgt_port.sv
module spi_tgt_port
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              sck_in,
  input  logic              csn_in,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              irq_out
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [1:0] rst_q;
  logic       rst_n_i;
  logic       sck_s, csn_s, mosi_s, cs_act;
  logic       lead_ev, samp_ev, shift_ev;
  logic       load_en, busy_q, done_ev;
  logic       done_q, ovr_q, col_q, armed_q, blocked;
  logic [DATA_W-1:0] shreg_q, rx_byte, rxbuf_q;
  logic [CNT_W-1:0]  bitcnt_q;
  ctrl_t             ctrl_q;

  // reset is asserted at once and released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_i = rst_q[1];

  spi_tgt_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_i),
    .d    ({sck_in, csn_in, mosi_in}),
    .q    ({sck_s, csn_s, mosi_s})
  );
  assign cs_act = ~csn_s;

  spi_tgt_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .sck_s   (sck_s),
    .cpol    (ctrl_q.cpol),
    .cpha    (ctrl_q.cpha),
    .lead_ev (lead_ev),
    .samp_ev (samp_ev),
    .shift_ev(shift_ev)
  );

  spi_tgt_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .enable   (ctrl_q.enable),
    .cs_act   (cs_act),
    .mosi_s   (mosi_s),
    .lead_ev  (lead_ev),
    .samp_ev  (samp_ev),
    .shift_ev (shift_ev),
    .load_en  (load_en),
    .load_data(host_wdata),
    .shreg_q  (shreg_q),
    .busy_q   (busy_q),
    .bitcnt_q (bitcnt_q),
    .done_ev  (done_ev),
    .rx_byte  (rx_byte)
  );

  spi_tgt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .done_ev   (done_ev),
    .rx_byte   (rx_byte),
    .cs_act    (cs_act),
    .busy      (busy_q),
    .ctrl_q    (ctrl_q),
    .load_en   (load_en),
    .irq       (irq_out),
    .done_q    (done_q),
    .ovr_q     (ovr_q),
    .col_q     (col_q),
    .armed_q   (armed_q),
    .blocked   (blocked),
    .rxbuf_q   (rxbuf_q)
  );

  assign miso_out = cs_act & ctrl_q.enable & shreg_q[DATA_W-1];
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              irq_out,
  input logic              done_q,
  input logic              ovr_q,
  input logic              col_q,
  input logic              armed_q,
  input logic [DATA_W-1:0] rxbuf_q,
  input logic              cs_act,
  input logic              cpha,
  input logic              enable,
  input logic [CNT_W-1:0]  bitcnt_q,
  input logic              done_ev
);
  logic data_rd, data_wr;
  assign data_rd = host_sel && !host_wr && host_addr == ADDR_DATA;
  assign data_wr = host_sel &&  host_wr && host_addr == ADDR_DATA;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !data_rd |=> done_q); // R4

  AST_BLOCKED_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && done_q && !armed_q && !col_q |=> !col_q); // R5

  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $stable(rxbuf_q)); // R6

  AST_COL_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !cpha && cs_act && !(done_q && !armed_q) |=> col_q); // R7

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bitcnt_q == '0); // R9

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> !irq_out); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done_ev); // R11
endmodule

bind spi_tgt_port spi_tgt_chk #(.DATA_W(DATA_W), .CNT_W($clog2(DATA_W))) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .host_sel (host_sel),
  .host_wr  (host_wr),
  .host_addr(host_addr),
  .irq_out  (irq_out),
  .done_q   (done_q),
  .ovr_q    (ovr_q),
  .col_q    (col_q),
  .armed_q  (armed_q),
  .rxbuf_q  (rxbuf_q),
  .cs_act   (cs_act),
  .cpha     (ctrl_q.cpha),
  .enable   (ctrl_q.enable),
  .bitcnt_q (bitcnt_q),
  .done_ev  (done_ev)
);

// File: tb/spi_tgt_port_test.sv
`timescale 1ns/1ps
module spi_tgt_port_test;
  localparam int H = 8;

  logic       clk, rst_n;
  logic       host_sel, host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       sck, csn, mosi, miso, irq;
  logic       cur_cpol, cur_cpha;
  int         n_cmp, n_bad;
  bit         done_flag;

  spi_tgt_port uut (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sck_in(sck), .csn_in(csn), .mosi_in(mosi),
    .miso_out(miso), .irq_out(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic host_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic set_mode(logic cp, logic ph, logic ie, logic en);
    cur_cpol = cp; cur_cpha = ph;
    host_write(2'd0, {4'b0, cp, ph, ie, en});
    sck = cp;
    wait_clk(H);
  endtask

  task automatic sel_low;
    csn = 1'b0; wait_clk(H);
  endtask

  task automatic sel_high;
    csn = 1'b1; wait_clk(H);
  endtask

  // runs the top n bits of mt; returns the bits seen on data-out
  task automatic shift_bits(logic [7:0] mt, int n, output logic [7:0] seen);
    seen = '0;
    for (int i = 7; i > 7 - n; i--) begin
      if (!cur_cpha) begin
        mosi = mt[i]; wait_clk(H);
        seen[i] = miso;
        sck = ~cur_cpol; wait_clk(H);
        sck = cur_cpol;
      end else begin
        sck = ~cur_cpol; mosi = mt[i]; wait_clk(H);
        seen[i] = miso;
        sck = cur_cpol; wait_clk(H);
      end
    end
    wait_clk(H);
  endtask

  task automatic full_byte(logic [7:0] mt, output logic [7:0] seen);
    sel_low;
    shift_bits(mt, 8, seen);
    sel_high;
  endtask

  task automatic clear_flags(output logic [7:0] d);
    logic [7:0] s;
    host_read(2'd1, s);
    host_read(2'd2, d);
  endtask

  initial begin
    done_flag = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got 00 exp 01");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, seen, tx, mt;
    n_cmp = 0; n_bad = 0;
    host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    sck = 0; csn = 1; mosi = 0; cur_cpol = 0; cur_cpha = 0;
    rst_n = 0;
    wait_clk(4);
    rst_n = 1;
    wait_clk(4);

    // R1 reset state
    host_read(2'd1, r); check("R1 status", r, 8'h00);
    host_read(2'd0, r); check("R1 ctrl", r, 8'h00);
    host_read(2'd2, r); check("R1 rxbuf", r, 8'h00);
    check("R1 miso", {7'b0, miso}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R12 control read-back and unused address
    host_write(2'd0, 8'hFF);
    host_read(2'd0, r); check("R12 ctrl", r, 8'h0F);
    host_read(2'd3, r); check("R12 addr3", r, 8'h00);

    // R2 R3 R4 R10 sweep across every mode and many bytes
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 12; k++) begin
        tx = 8'((k * 53 + m * 29 + 7) & 255);
        mt = 8'((k * 91 + m * 17 + 200) & 255);
        set_mode(m[1], m[0], 1'b1, 1'b1);
        host_write(2'd2, tx);
        full_byte(mt, seen);
        check("R2 miso byte", seen, tx);
        check("R10 irq up", {7'b0, irq}, 8'h01);
        host_read(2'd1, r); check("R3 status", r, 8'h80);
        host_read(2'd2, r); check("R3 rxbuf", r, mt);
        host_read(2'd1, r); check("R4 cleared", r, 8'h00);
        check("R10 irq down", {7'b0, irq}, 8'h00);
      end
    end

    // R4 data read alone does not clear
    set_mode(1'b0, 1'b0, 1'b1, 1'b1);
    full_byte(8'h5C, seen);
    host_read(2'd2, r); check("R4 early data", r, 8'h5C);
    host_read(2'd1, r); check("R4 still set", r, 8'h80);
    host_read(2'd2, r);
    host_read(2'd1, r); check("R4 clear seq", r, 8'h00);

    // R5 write refused before status read, accepted after
    full_byte(8'h81, seen);
    host_write(2'd2, 8'hA5);
    host_read(2'd1, r); check("R5 no col", r, 8'h80);
    host_read(2'd2, r);
    full_byte(8'h3E, seen);
    check("R5 blocked write", seen, 8'h81);
    clear_flags(r);
    full_byte(8'h44, seen);
    host_read(2'd1, r);
    host_write(2'd2, 8'h3C);
    host_read(2'd2, r); check("R5 data", r, 8'h44);
    full_byte(8'h00, seen);
    check("R5 accepted write", seen, 8'h3C);
    clear_flags(r);

    // R6 overrun keeps first byte
    full_byte(8'h11, seen);
    full_byte(8'h22, seen);
    host_read(2'd1, r); check("R6 status", r, 8'hA0);
    host_read(2'd2, r); check("R6 rxbuf", r, 8'h11);
    host_read(2'd1, r); check("R6 cleared", r, 8'h00);

    // R7 phase 0 collision while selected
    full_byte(8'h6D, seen);
    clear_flags(r);
    sel_low;
    host_write(2'd2, 8'h77);
    host_read(2'd1, r); check("R7 col flag", r, 8'h40);
    host_read(2'd2, r); check("R7 rxbuf", r, 8'h6D);
    shift_bits(8'h12, 8, seen);
    check("R7 dropped write", seen, 8'h6D);
    sel_high;
    clear_flags(r);

    // R8 phase 1 write between bytes vs mid byte; R9 abort
    set_mode(1'b0, 1'b1, 1'b1, 1'b1);
    sel_low;
    host_write(2'd2, 8'h5A);
    host_read(2'd1, r); check("R8 idle write", r, 8'h00);
    shift_bits(8'h96, 8, seen);
    check("R8 loaded byte", seen, 8'h5A);
    clear_flags(r); check("R8 rx", r, 8'h96);
    shift_bits(8'h00, 3, seen);
    host_write(2'd2, 8'hC3);
    sel_high;
    host_read(2'd1, r); check("R8 R9 col no done", r, 8'h40);
    clear_flags(r);
    full_byte(8'hE1, seen);
    host_read(2'd1, r); check("R9 restart status", r, 8'h80);
    host_read(2'd2, r); check("R9 restart data", r, 8'hE1);

    set_mode(1'b0, 1'b0, 1'b1, 1'b1);
    sel_low;
    shift_bits(8'hFF, 5, seen);
    sel_high;
    host_read(2'd1, r); check("R9 abort no done", r, 8'h00);
    full_byte(8'h4B, seen);
    host_read(2'd1, r); check("R9 status", r, 8'h80);
    host_read(2'd2, r); check("R9 data", r, 8'h4B);

    // R10 interrupt gating
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    full_byte(8'h9A, seen);
    check("R10 ie off", {7'b0, irq}, 8'h00);
    host_write(2'd0, 8'h03);
    check("R10 ie on", {7'b0, irq}, 8'h01);
    host_write(2'd0, 8'h02);
    check("R10 en off", {7'b0, irq}, 8'h00);
    clear_flags(r);

    // R11 disabled block ignores the serial side
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    full_byte(8'h3D, seen);
    host_read(2'd1, r); check("R11 status", r, 8'h00);
    host_read(2'd2, r); check("R11 rxbuf", r, 8'h9A);
    check("R11 irq", {7'b0, irq}, 8'h00);

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule